// File: doc/BRIEF.md
# Packed-Control Serial Port

This block is an asynchronous serial transmitter and receiver behind a two-address register window. Address 0 is the data port: a write queues one character for transmission, and a read takes the oldest received character together with three error flags. Address 1 is a single control word. It holds the bit-rate divisor and the character format: break, parity on or off, parity sense, stop-bit count, FIFO mode and character length.

Characters are 5 to 8 bits long and go out least-significant bit first. Each bit is timed with 16 ticks of an oversampling clock. The receiver confirms a start bit at the middle of the bit and samples each later bit at its centre. Each direction has its own queue. The queue is 16 deep when FIFO mode is on and holds one entry when it is off. Separate transmit and receive interrupt requests flag room in the transmit queue and data in the receive queue. A port-enable input stops or starts all line activity.

Top module: `lcr_uart`

## Requirements
- R1: Every bit on the line lasts 16 × (D + 1) clock cycles, where D is control bits 11:0.
- R2: A transmitted frame has a low start bit, then N = control[18:17] + 5 data bits LSB first. A parity bit follows when control[13] is 1. It is the XOR of the data bits when control[14] is 1 (even) and its inverse when control[14] is 0 (odd). Then come one high stop bit, or two when control[15] is 1.
- R3: While control[12] is 1, txd is held low. Clearing it returns txd to its normal level.
- R4: A read at address 0 returns the received character in bits 7:0, zero-extended above N bits. A write at address 0 queues bits 7:0. Address 1 reads back the 19 control bits in 18:0, with zeros above them.
- R5: With control[16] = 1 each queue holds 16 entries; with 0 it holds one. txFull rises exactly when the transmit queue is full, and a write to a full queue is dropped.
- R6: busy is high from the write of a character until its last stop bit has ended, then low.
- R7: txIrq = portEn AND NOT txFull; rxIrq = portEn AND NOT rxEmpty.
- R8: A character completed while the receive queue is full is discarded. The next stored character carries bit 10 (overrun) set.
- R9: A low pulse on rxd shorter than half a bit time produces no character.
- R10: While portEn is low, txd idles high and queued characters wait. They go out, in order, once portEn rises.
- R11: After reset: rxEmpty = 1, txFull = 0, busy = 0, txd = 1, and the control word reads 0.
- R12: A received character sets bit 9 when its parity bit disagrees with the configured sense. It sets bit 8 when its first stop bit is sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| portEn | input | 1 | Port enable; low idles the line and the baud counter |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe; pops the receive queue at address 0 |
| addr | input | 1 | 0 = data port, 1 = control word |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for the addressed register |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |
| rxEmpty | output | 1 | Receive queue empty |
| txFull | output | 1 | Transmit queue full |
| busy | output | 1 | Transmitter has queued or in-flight data |
| txIrq | output | 1 | Transmit interrupt request |
| rxIrq | output | 1 | Receive interrupt request |

## Verification
The embedded properties check, on every cycle, the invariants that hold cycle by cycle:
- queue counts never exceed the depth, and they change only on a push or a pop;
- a full queue drops a push;
- an overrun drops the character instead of pushing it;
- the line is high whenever busy falls, and the start bit drives the line low;
- the oversampling tick never fires twice in a row when the divisor is nonzero.

The bench scenarios cover what needs whole frames. They measure the bit period for two divisors and decode transmitted frames at mid-bit for three formats. They also drive received frames with good and bad parity, a low stop bit, a short glitch and an overflow. Finally they fill both queue depths while the port is off and check the drain order once it is enabled.

// File: rtl/lcr_uart_pkg.sv
package lcr_uart_pkg;
  localparam int DIV_W  = 12;
  localparam int DATA_W = 8;
  localparam int RX_W   = DATA_W + 3;
  localparam int BUS_W  = 32;
  localparam int OVS    = 16;
  localparam int TICK_W = $clog2(OVS);
  localparam int CFG_W  = DIV_W + 7;
  localparam logic REG_DATA = 1'b0;
  localparam logic REG_LINE = 1'b1;

  // Field order follows the control word bit positions (MSB first).
  typedef struct packed {
    logic [1:0]       wordLen;
    logic             fifoEn;
    logic             twoStop;
    logic             evenPar;
    logic             parEn;
    logic             brk;
    logic [DIV_W-1:0] divisor;
  } lineCfg_t;

  typedef struct packed {
    logic txPush;
    logic rxPop;
    logic tick;
    logic runEn;
  } strobe_t;

  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP} frameSt_t;

  function automatic logic [3:0] charBits(input logic [1:0] wl);
    return {2'b00, wl} + 4'd5;
  endfunction
endpackage

// File: rtl/lcr_uart_fifo.sv
module lcr_uart_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             deep,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wData,
  output logic [WIDTH-1:0] rData,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wPtr, rPtr;
  logic [CW-1:0]    cnt;
  logic             doPush, doPop;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign empty  = (cnt == '0);
  assign full   = deep ? (cnt == CW'(DEPTH)) : (cnt != '0);
  assign rData  = mem[rPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wPtr] <= wData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wPtr <= '0;
      rPtr <= '0;
      cnt  <= '0;
    end else begin
      if (doPush) wPtr <= nextPtr(wPtr);
      if (doPop)  rPtr <= nextPtr(rPtr);
      cnt <= cnt + CW'(doPush) - CW'(doPop);
    end
  end

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CW'(DEPTH));
  a_r5_count_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !push && !pop |=> $stable(cnt));
  a_r5_full_drops: assert property (@(posedge clk) disable iff (!rstN)
    full && push && !pop |=> $stable(cnt));
endmodule

// File: rtl/lcr_uart_ctrl.sv
module lcr_uart_ctrl
  import lcr_uart_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             portEn,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic             addr,
  input  logic [BUS_W-1:0] wrData,
  input  logic             rxEmpty,
  input  logic             txFull,
  output lineCfg_t         cfg,
  output strobe_t          strb
);
  logic [DIV_W-1:0] baudCnt;
  logic             tickNow;
  logic             unusedHi;

  assign unusedHi = ^wrData[BUS_W-1:CFG_W];
  assign tickNow  = portEn && (baudCnt >= cfg.divisor);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          cfg <= '0;
    else if (wrEn && addr == REG_LINE)  cfg <= lineCfg_t'(wrData[CFG_W-1:0]);
  end

  // Divide by (D+1) to make the 16x oversampling tick.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                    baudCnt <= '0;
    else if (!portEn || baudCnt >= cfg.divisor)   baudCnt <= '0;
    else                                          baudCnt <= baudCnt + 1'b1;
  end

  always_comb begin
    strb.tick   = tickNow;
    strb.runEn  = portEn;
    strb.txPush = wrEn && addr == REG_DATA && !txFull;
    strb.rxPop  = rdEn && addr == REG_DATA && !rxEmpty;
  end

  a_r1_tick_spacing: assert property (@(posedge clk) disable iff (!rstN)
    cfg.divisor != '0 && strb.tick && !(wrEn && addr == REG_LINE) |=> !strb.tick);
endmodule

// File: rtl/lcr_uart_dp.sv
module lcr_uart_dp
  import lcr_uart_pkg::*;
#(
  parameter int FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  lineCfg_t          cfg,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] wrByte,
  input  logic              rxd,
  output logic              txd,
  output logic              busy,
  output logic [RX_W-1:0]   rxHead,
  output logic              rxEmpty,
  output logic              txFull
);
  localparam int HALF = OVS / 2;

  logic [3:0] nBits;
  assign nBits = charBits(cfg.wordLen);

  // ---------------- transmit ----------------
  logic [DATA_W-1:0] txHead, txShift;
  logic              txEmpty, txPop, txLine, txPar, txSecond;
  logic [TICK_W-1:0] txTick;
  logic [2:0]        txBit;
  frameSt_t          txSt;

  lcr_uart_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_txFifo (
    .clk(clk), .rstN(rstN), .deep(cfg.fifoEn), .push(strb.txPush), .pop(txPop),
    .wData(wrByte), .rData(txHead), .empty(txEmpty), .full(txFull));

  assign txPop = strb.runEn && strb.tick && txSt == ST_IDLE && !txEmpty;
  assign busy  = (txSt != ST_IDLE) || !txEmpty;
  assign txd   = cfg.brk ? 1'b0 : txLine;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSt <= ST_IDLE; txLine <= 1'b1; txTick <= '0; txBit <= '0;
      txShift <= '0; txPar <= 1'b0; txSecond <= 1'b0;
    end else if (!strb.runEn) begin
      txSt <= ST_IDLE; txLine <= 1'b1; txTick <= '0;
    end else if (strb.tick) begin
      if (txSt == ST_IDLE) begin
        if (!txEmpty) begin
          txShift <= txHead; txSt <= ST_START; txLine <= 1'b0; txTick <= '0;
        end
      end else begin
        txTick <= txTick + 1'b1;
        if (txTick == TICK_W'(OVS - 1)) begin
          case (txSt)
            ST_START: begin
              txSt <= ST_DATA; txLine <= txShift[0]; txPar <= txShift[0];
              txShift <= txShift >> 1; txBit <= '0;
            end
            ST_DATA: begin
              if ({1'b0, txBit} == nBits - 4'd1) begin
                if (cfg.parEn) begin
                  txSt <= ST_PAR; txLine <= cfg.evenPar ? txPar : ~txPar;
                end else begin
                  txSt <= ST_STOP; txLine <= 1'b1; txSecond <= 1'b0;
                end
              end else begin
                txLine <= txShift[0]; txPar <= txPar ^ txShift[0];
                txShift <= txShift >> 1; txBit <= txBit + 1'b1;
              end
            end
            ST_PAR: begin
              txSt <= ST_STOP; txLine <= 1'b1; txSecond <= 1'b0;
            end
            ST_STOP: begin
              if (cfg.twoStop && !txSecond) txSecond <= 1'b1;
              else                          txSt <= ST_IDLE;
            end
            default: txSt <= ST_IDLE;
          endcase
        end
      end
    end
  end

  // ---------------- receive ----------------
  logic              rxMeta, rxS, rxFull, rxPush, rxParAcc, rxParErr, ovrPend;
  logic [RX_W-1:0]   rxEntry;
  logic [DATA_W-1:0] rxData;
  logic [TICK_W-1:0] rxTick;
  logic [2:0]        rxBit;
  frameSt_t          rxSt;

  lcr_uart_fifo #(.WIDTH(RX_W), .DEPTH(FIFO_DEPTH)) u_rxFifo (
    .clk(clk), .rstN(rstN), .deep(cfg.fifoEn), .push(rxPush), .pop(strb.rxPop),
    .wData(rxEntry), .rData(rxHead), .empty(rxEmpty), .full(rxFull));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxMeta <= 1'b1; rxS <= 1'b1;
    end else begin
      rxMeta <= rxd; rxS <= rxMeta;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSt <= ST_IDLE; rxTick <= '0; rxBit <= '0; rxData <= '0; rxParAcc <= 1'b0;
      rxParErr <= 1'b0; ovrPend <= 1'b0; rxPush <= 1'b0; rxEntry <= '0;
    end else if (!strb.runEn) begin
      rxSt <= ST_IDLE; rxPush <= 1'b0;
    end else begin
      rxPush <= 1'b0;
      if (strb.tick) begin
        case (rxSt)
          ST_IDLE: if (!rxS) begin rxSt <= ST_START; rxTick <= '0; end
          ST_START: begin
            rxTick <= rxTick + 1'b1;
            if (rxTick == TICK_W'(HALF - 1)) begin
              if (!rxS) begin
                rxSt <= ST_DATA; rxTick <= '0; rxBit <= '0; rxData <= '0;
                rxParAcc <= 1'b0; rxParErr <= 1'b0;
              end else begin
                rxSt <= ST_IDLE;
              end
            end
          end
          ST_DATA: begin
            rxTick <= rxTick + 1'b1;
            if (rxTick == TICK_W'(OVS - 1)) begin
              rxData[rxBit] <= rxS;
              rxParAcc <= rxParAcc ^ rxS;
              rxBit <= rxBit + 1'b1;
              if ({1'b0, rxBit} == nBits - 4'd1) rxSt <= cfg.parEn ? ST_PAR : ST_STOP;
            end
          end
          ST_PAR: begin
            rxTick <= rxTick + 1'b1;
            if (rxTick == TICK_W'(OVS - 1)) begin
              rxParErr <= rxS != (cfg.evenPar ? rxParAcc : ~rxParAcc);
              rxSt <= ST_STOP;
            end
          end
          ST_STOP: begin
            rxTick <= rxTick + 1'b1;
            if (rxTick == TICK_W'(OVS - 1)) begin
              rxSt <= ST_IDLE;
              if (rxFull) begin
                ovrPend <= 1'b1;
              end else begin
                rxPush  <= 1'b1;
                rxEntry <= {ovrPend, rxParErr, !rxS, rxData};
                ovrPend <= 1'b0;
              end
            end
          end
          default: rxSt <= ST_IDLE;
        endcase
      end
    end
  end

  a_r2_start_low: assert property (@(posedge clk) disable iff (!rstN)
    txSt == ST_START |-> !txLine);
  a_r6_line_high_at_idle: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.brk && $fell(busy) |-> txd);
  a_r8_no_push_when_full: assert property (@(posedge clk) disable iff (!rstN)
    rxPush |-> !rxFull);
endmodule

// File: rtl/lcr_uart.sv
module lcr_uart
  import lcr_uart_pkg::*;
#(
  parameter int FIFO_DEPTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             portEn,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic             addr,
  input  logic [BUS_W-1:0] wrData,
  output logic [BUS_W-1:0] rdData,
  input  logic             rxd,
  output logic             txd,
  output logic             rxEmpty,
  output logic             txFull,
  output logic             busy,
  output logic             txIrq,
  output logic             rxIrq
);
  lineCfg_t        cfg;
  strobe_t         strb;
  logic [RX_W-1:0] rxHead;

  lcr_uart_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .portEn(portEn), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rxEmpty(rxEmpty), .txFull(txFull), .cfg(cfg), .strb(strb));

  lcr_uart_dp #(.FIFO_DEPTH(FIFO_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .cfg(cfg), .strb(strb), .wrByte(wrData[DATA_W-1:0]),
    .rxd(rxd), .txd(txd), .busy(busy), .rxHead(rxHead), .rxEmpty(rxEmpty), .txFull(txFull));

  assign rdData = (addr == REG_LINE) ? {{(BUS_W-CFG_W){1'b0}}, cfg}
                                     : {{(BUS_W-RX_W){1'b0}}, rxHead};
  assign txIrq  = portEn && !txFull;
  assign rxIrq  = portEn && !rxEmpty;
endmodule

// File: tb/lcr_uart_bench.sv
module lcr_uart_bench;
  localparam int DIVV   = 1;
  localparam int BITCLK = 16 * (DIVV + 1);

  logic clk = 0, rstN = 0, portEn = 0, wrEn = 0, rdEn = 0, addr = 0, rxLine = 1;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic txd, rxEmpty, txFull, busy, txIrq, rxIrq;
  int nChecks = 0, nFail = 0;

  always #10 clk = ~clk;

  lcr_uart u_lcr_uart (
    .clk(clk), .rstN(rstN), .portEn(portEn), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .rxd(rxLine), .txd(txd), .rxEmpty(rxEmpty),
    .txFull(txFull), .busy(busy), .txIrq(txIrq), .rxIrq(rxIrq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkLcr(input int len, input bit parEn, input bit even,
                                        input bit two, input bit fifo, input bit brk, input int dv);
    return {13'b0, 2'(len - 5), fifo, two, even, parEn, brk, 12'(dv)};
  endfunction

  task automatic busWrite(input logic a, input logic [31:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic busRead(input logic a, output logic [31:0] d);
    @(negedge clk); addr = a; rdEn = 1; #1 d = rdData;
    @(negedge clk); rdEn = 0;
  endtask

  task automatic waitIdle();
    int t = 0;
    while (busy && t < 20000) begin @(negedge clk); t++; end
    repeat (4) @(negedge clk);
  endtask

  task automatic captureTx(input int nb, input bit hasPar, input int nStop,
                           output logic [7:0] d, output logic p, output logic fr);
    int t = 0;
    d = '0; p = 0; fr = 1;
    while (txd !== 1'b0 && t < 20000) begin @(negedge clk); t++; end
    repeat (BITCLK / 2) @(negedge clk);
    if (txd !== 1'b0) fr = 0;
    for (int i = 0; i < nb; i++) begin repeat (BITCLK) @(negedge clk); d[i] = txd; end
    if (hasPar) begin repeat (BITCLK) @(negedge clk); p = txd; end
    for (int s = 0; s < nStop; s++) begin
      repeat (BITCLK) @(negedge clk);
      if (txd !== 1'b1) fr = 0;
    end
  endtask

  task automatic sendRx(input logic [7:0] d, input int nb, input bit hasPar,
                        input bit parVal, input bit stopVal);
    rxLine = 0; repeat (BITCLK) @(negedge clk);
    for (int i = 0; i < nb; i++) begin rxLine = d[i]; repeat (BITCLK) @(negedge clk); end
    if (hasPar) begin rxLine = parVal; repeat (BITCLK) @(negedge clk); end
    rxLine = stopVal;
    repeat (stopVal ? BITCLK : 24) @(negedge clk);
    rxLine = 1; repeat (2 * BITCLK) @(negedge clk);
  endtask

  function automatic logic parOf(input logic [7:0] d, input int nb, input bit even);
    logic x = 0;
    for (int i = 0; i < nb; i++) x ^= d[i];
    return even ? x : ~x;
  endfunction

  task automatic txFrame(input string req, input int nb, input bit pe, input bit ev,
                         input bit two, input logic [7:0] val);
    logic [7:0] d; logic p, fr;
    logic [7:0] m = 8'((1 << nb) - 1);
    busWrite(1, mkLcr(nb, pe, ev, two, 0, 0, DIVV));
    busWrite(0, {24'b0, val});
    captureTx(nb, pe, two ? 2 : 1, d, p, fr);
    check({req, " data"}, d, val & m);
    check({req, " start/stop"}, fr, 1);
    if (pe) check({req, " parity"}, p, parOf(val, nb, ev));
    if (two) check({req, " busy through second stop"}, busy, 1);
    waitIdle();
  endtask

  task automatic testReset();
    logic [31:0] r;
    check("R11 rxEmpty", rxEmpty, 1);
    check("R11 txFull", txFull, 0);
    check("R11 busy", busy, 0);
    check("R11 txd", txd, 1);
    busRead(1, r);
    check("R11 control", r, 0);
  endtask

  task automatic testRegs();
    logic [31:0] r;
    busWrite(1, 32'hFFFF_FFFF);
    busRead(1, r);
    check("R4 control readback", r, 32'h0007_FFFF);
    check("R3 break drives low", txd, 0);
    busWrite(1, mkLcr(8, 0, 0, 0, 0, 0, DIVV));
    check("R3 break released", txd, 1);
  endtask

  task automatic testRate(input int dv);
    int len = 0, t = 0;
    busWrite(1, mkLcr(8, 0, 0, 0, 0, 0, dv));
    busWrite(0, 32'h01);
    while (txd !== 1'b0 && t < 5000) begin @(negedge clk); t++; end
    while (txd === 1'b0 && len < 1000) begin @(negedge clk); len++; end
    check("R1 start bit length", len, 16 * (dv + 1));
    waitIdle();
  endtask

  task automatic testBusy();
    logic [7:0] d; logic p, fr;
    busWrite(1, mkLcr(8, 0, 0, 0, 0, 0, DIVV));
    busWrite(0, 32'h5A);
    check("R6 busy after write", busy, 1);
    captureTx(8, 0, 1, d, p, fr);
    repeat (8) @(negedge clk);
    check("R6 busy during stop", busy, 1);
    repeat (12) @(negedge clk);
    check("R6 busy after stop", busy, 0);
  endtask

  task automatic testBreak();
    busWrite(1, mkLcr(8, 0, 0, 0, 0, 1, DIVV));
    check("R3 break low", txd, 0);
    repeat (100) @(negedge clk);
    check("R3 break held", txd, 0);
    busWrite(1, mkLcr(8, 0, 0, 0, 0, 0, DIVV));
    check("R3 break cleared", txd, 1);
  endtask

  task automatic rxOne(input string req, input int nb, input bit pe, input bit ev,
                       input logic [7:0] val, input bit badPar, input bit stopVal,
                       input logic [31:0] exp);
    logic [31:0] r;
    busWrite(1, mkLcr(nb, pe, ev, 0, 1, 0, DIVV));
    sendRx(val, nb, pe, parOf(val, nb, ev) ^ badPar, stopVal);
    check({req, " rxIrq"}, rxIrq, 1);
    busRead(0, r);
    check({req, " entry"}, r, exp);
    check({req, " emptied"}, rxEmpty, 1);
  endtask

  task automatic testGlitch();
    busWrite(1, mkLcr(8, 0, 0, 0, 1, 0, DIVV));
    rxLine = 0; repeat (6) @(negedge clk); rxLine = 1;
    repeat (400) @(negedge clk);
    check("R9 glitch ignored", rxEmpty, 1);
  endtask

  task automatic testOverrun();
    logic [31:0] r;
    busWrite(1, mkLcr(8, 0, 0, 0, 0, 0, DIVV));
    sendRx(8'h11, 8, 0, 0, 1);
    sendRx(8'h22, 8, 0, 0, 1);
    busRead(0, r);
    check("R8 first kept", r, 32'h011);
    check("R8 second discarded", rxEmpty, 1);
    sendRx(8'h33, 8, 0, 0, 1);
    busRead(0, r);
    check("R8 overrun flag", r, 32'h433);
  endtask

  task automatic testFifo();
    logic [7:0] d; logic p, fr;
    portEn = 0;
    busWrite(1, mkLcr(8, 0, 0, 0, 1, 0, DIVV));
    for (int i = 0; i < 15; i++) busWrite(0, 32'((i * 7 + 3) & 8'hFF));
    check("R5 not full at 15", txFull, 0);
    busWrite(0, 32'((15 * 7 + 3) & 8'hFF));
    check("R5 full at 16", txFull, 1);
    busWrite(0, 32'hEE);
    repeat (300) @(negedge clk);
    check("R10 idle while disabled", txd, 1);
    check("R7 txIrq gated", txIrq, 0);
    @(negedge clk); portEn = 1; #1;
    check("R7 txIrq low when full", txIrq, 0);
    for (int i = 0; i < 16; i++) begin
      captureTx(8, 0, 1, d, p, fr);
      check("R10 drain order", d, 8'((i * 7 + 3) & 8'hFF));
      if (i == 0) check("R7 txIrq with room", txIrq, 1);
    end
    repeat (400) @(negedge clk);
    check("R5 dropped write never sent", busy, 0);
    check("R5 line idle", txd, 1);
    portEn = 0;
    busWrite(1, mkLcr(8, 0, 0, 0, 0, 0, DIVV));
    busWrite(0, 32'h5A);
    check("R5 depth one full", txFull, 1);
    busWrite(0, 32'h66);
    @(negedge clk); portEn = 1;
    captureTx(8, 0, 1, d, p, fr);
    check("R5 depth one data", d, 8'h5A);
    repeat (400) @(negedge clk);
    check("R5 depth one drop", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testRegs();
    portEn = 1;
    txFrame("R2 8N1", 8, 0, 0, 0, 8'hA5);
    txFrame("R2 7E2", 7, 1, 1, 1, 8'h34);
    txFrame("R2 5O1", 5, 1, 0, 0, 8'h15);
    testRate(DIVV);
    testRate(3);
    testBusy();
    testBreak();
    rxOne("R4 8N1", 8, 0, 0, 8'h3C, 0, 1, 32'h03C);
    rxOne("R4 6-bit", 6, 0, 0, 8'h2A, 0, 1, 32'h02A);
    rxOne("R12 good parity", 8, 1, 1, 8'h0F, 0, 1, 32'h00F);
    rxOne("R12 bad parity", 8, 1, 1, 8'h0F, 1, 1, 32'h20F);
    rxOne("R12 odd parity bad", 7, 1, 0, 8'h41, 1, 1, 32'h241);
    rxOne("R12 framing", 8, 0, 0, 8'h55, 0, 0, 32'h155);
    testGlitch();
    testOverrun();
    testFifo();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule